// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in system memory and passes each frame that software has handed over to a downstream frame fetcher. Each descriptor occupies a fixed stride of memory (16 bytes by default). It holds three 32-bit words. The word at offset 0 carries control and status. The word at offset 4 carries the frame length in its upper halfword. The word at offset 8 carries the buffer address. The engine reaches memory through a simple request/acknowledge port, which it uses both to read descriptors and to write status back. It gives the length and address to the fetcher and holds them until the fetcher acknowledges that the frame has been sent.

Software first loads the ring base address while the engine is idle, fills descriptors and sets the transmit request. The engine then runs through these states. ST_IDLE moves to ST_FETCH_CTL once the request is set. ST_FETCH_CTL moves to ST_FETCH_LEN on a fetched word that is owned by hardware. It returns to ST_IDLE on a word that is not owned, and this return is the stop transition. ST_FETCH_LEN moves to ST_FETCH_BUF. ST_FETCH_BUF moves to ST_HANDOFF when the descriptor can be sent, and to ST_WRITEBACK when it is skipped. ST_HANDOFF moves to ST_WRITEBACK on the fetcher's acknowledge. ST_WRITEBACK returns to ST_FETCH_CTL with the ring pointer advanced. On the stop transition the engine clears the transmit request and keeps its pointer. A later request therefore resumes at the same descriptor.

Bit positions in the control word: 31 marks the descriptor as owned by hardware, 30 marks it as the last in the ring, 28 marks it as holding a whole frame, and 27 is the skip-error flag that the engine reports.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the transmit request, the memory request and the frame-valid output are all low, and the engine stays quiet until a request is set.
- R2: A request pulse makes the engine read the descriptor at the current pointer: the control word at pointer+0, the length word at pointer+4 and the address word at pointer+8.
- R3: For a descriptor that can be sent, frame length equals bits 31:16 of the length word (up to 0xFFFF) and frame address equals the address word. Both are held stable with frame-valid high until the done pulse.
- R4: After the handoff completes, the engine writes the control word back to pointer+0 with bit 31 (owned) cleared and bit 27 cleared. All other bits keep the values that were fetched.
- R5: Bit 30 (last) survives the write-back. A descriptor with bit 30 set sends the next fetch to the ring base, and without it the next fetch goes to pointer+16.
- R6: If a fetched control word has bit 31 clear, the engine drops the transmit request and returns to idle. It hands off no frame and writes nothing.
- R7: A stop does not advance the pointer, so the next request fetches the same descriptor again.
- R8: A descriptor is skipped if its buffer address has bits 1:0 nonzero, if bit 28 is clear, or if its length is zero. A skipped descriptor raises no frame-valid. It is written back with bit 31 cleared and bit 27 set, and the ring advances past it.
- R9: A base-load pulse sets both the ring base and the pointer only while the engine is idle with no request pending. While the engine runs, the pulse is ignored.
- R10: A memory request keeps its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base_i | input | ADDR_W | Ring base address, taken on a base-load pulse |
| base_load_i | input | 1 | Load ring base and pointer (idle only) |
| tx_req_set_i | input | 1 | Pulse that sets the transmit request |
| tx_req_o | output | 1 | Transmit request; cleared by the engine when it stops |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Write data (status write-back) |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Memory read data |
| frm_valid_o | output | 1 | Frame handoff valid |
| frm_addr_o | output | ADDR_W | Frame buffer address |
| frm_len_o | output | 16 | Frame length in bytes |
| frm_done_i | input | 1 | Fetcher acknowledge that the frame is sent |

## Verification
The hardest situation to reach from the ports is a base-load pulse that arrives while the engine is part-way through the ring. The stimulus makes the frame acknowledge slow on purpose. This holds the engine in ST_HANDOFF, and during that window it pulses base-load with a second ring that carries an owned descriptor. The frames that follow must come only from the first ring. A later request must also resume in the first ring. A second subtle case is the stop-and-resume pair. A ring is left with a descriptor that is not owned, and after the engine stops that descriptor is made owned. The next frame must then be the one at the stopped position and not the one after it.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 16;
    localparam int OWN_BIT   = 31;
    localparam int LAST_BIT  = 30;
    localparam int WHOLE_BIT = 28;
    localparam int ERR_BIT   = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_LEN,
        ST_FETCH_BUF,
        ST_HANDOFF,
        ST_WRITEBACK
    } state_t;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load_i) begin
            base_q <= ring_base_i;
            cur_q  <= ring_base_i;
        end else if (advance_i) begin
            cur_q  <= wrap_i ? base_q : cur_q + STEP;
        end
    end

    assign cur_o  = cur_q;
    assign base_o = base_q;
endmodule

// File: rtl/tx_ring_desc.sv
module tx_ring_desc
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            state_i,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              sendable_o,
    output logic              last_o,
    output logic [WORD_W-1:0] wb_data_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] buf_o
);
    logic [WORD_W-1:0] ctl_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] buf_q;
    logic              skip_q;

    // Evaluated while the address word is on the read bus
    assign sendable_o = (rdata_i[1:0] == 2'b00) && ctl_q[WHOLE_BIT] && (len_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            len_q  <= '0;
            buf_q  <= '0;
            skip_q <= 1'b0;
        end else if (mem_ack_i) begin
            unique case (state_i)
                ST_FETCH_CTL: ctl_q <= rdata_i;
                ST_FETCH_LEN: len_q <= rdata_i[WORD_W-1 -: LEN_W];
                ST_FETCH_BUF: begin
                    buf_q  <= rdata_i[ADDR_W-1:0];
                    skip_q <= ~sendable_o;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wb_data_o          = ctl_q;
        wb_data_o[OWN_BIT] = 1'b0;
        wb_data_o[ERR_BIT] = skip_q;
    end

    assign last_o = ctl_q[LAST_BIT];
    assign len_o  = len_q;
    assign buf_o  = buf_q;
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
    import tx_ring_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_set_i,
    input  logic       mem_ack_i,
    input  logic       own_i,
    input  logic       sendable_i,
    input  logic       frm_done_i,
    output state_t     state_o,
    output logic       tx_req_o,
    output logic       advance_o,
    output logic       mem_req_o,
    output logic       mem_we_o,
    output logic [3:0] word_off_o,
    output logic       frm_valid_o
);
    state_t state_q, state_d;
    logic   tx_req_q;
    logic   stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tx_req_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            tx_req_q <= (tx_req_q & ~stop) | req_set_i;
        end
    end

    always_comb begin
        state_d   = state_q;
        stop      = 1'b0;
        advance_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      if (tx_req_q) state_d = ST_FETCH_CTL;
            ST_FETCH_CTL: if (mem_ack_i) begin
                if (own_i) state_d = ST_FETCH_LEN;
                else begin
                    stop    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FETCH_LEN: if (mem_ack_i) state_d = ST_FETCH_BUF;
            ST_FETCH_BUF: if (mem_ack_i) state_d = sendable_i ? ST_HANDOFF : ST_WRITEBACK;
            ST_HANDOFF:   if (frm_done_i) state_d = ST_WRITEBACK;
            ST_WRITEBACK: if (mem_ack_i) begin
                advance_o = 1'b1;
                state_d   = ST_FETCH_CTL;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        word_off_o  = 4'd0;
        frm_valid_o = 1'b0;
        unique case (state_q)
            ST_FETCH_CTL: mem_req_o = 1'b1;
            ST_FETCH_LEN: begin mem_req_o = 1'b1; word_off_o = 4'd4; end
            ST_FETCH_BUF: begin mem_req_o = 1'b1; word_off_o = 4'd8; end
            ST_HANDOFF:   frm_valid_o = 1'b1;
            ST_WRITEBACK: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
            default: ;
        endcase
    end

    assign state_o  = state_q;
    assign tx_req_o = tx_req_q;
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              base_load_i,
    input  logic              tx_req_set_i,
    output logic              tx_req_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              frm_valid_o,
    output logic [ADDR_W-1:0] frm_addr_o,
    output logic [15:0]       frm_len_o,
    input  logic              frm_done_i
);
    state_t            state;
    logic              advance, sendable, last, load;
    logic [3:0]        word_off;
    logic [ADDR_W-1:0] cur_ptr, base_ptr;

    tx_ring_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set_i  (tx_req_set_i),
        .mem_ack_i  (mem_ack_i),
        .own_i      (mem_rdata_i[OWN_BIT]),
        .sendable_i (sendable),
        .frm_done_i (frm_done_i),
        .state_o    (state),
        .tx_req_o   (tx_req_o),
        .advance_o  (advance),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .word_off_o (word_off),
        .frm_valid_o(frm_valid_o)
    );

    tx_ring_desc #(.ADDR_W(ADDR_W)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .mem_ack_i (mem_ack_i),
        .rdata_i   (mem_rdata_i),
        .sendable_o(sendable),
        .last_o    (last),
        .wb_data_o (mem_wdata_o),
        .len_o     (frm_len_o),
        .buf_o     (frm_addr_o)
    );

    // Base may only move while nothing is in flight or pending
    assign load = base_load_i && (state == ST_IDLE) && !tx_req_o;

    tx_ring_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_base_i(ring_base_i),
        .load_i     (load),
        .advance_i  (advance),
        .wrap_i     (last),
        .cur_o      (cur_ptr),
        .base_o     (base_ptr)
    );

    assign mem_addr_o = cur_ptr + ADDR_W'(word_off);
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input state_t            state,
    input logic              tx_req_set_i,
    input logic              tx_req_o,
    input logic              base_load_i,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_ack_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic [31:0]       mem_rdata_i,
    input logic              frm_valid_o,
    input logic              frm_done_i,
    input logic [ADDR_W-1:0] frm_addr_o,
    input logic [15:0]       frm_len_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_req_o && !frm_valid_o));

    p_frm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && !frm_done_i) |=> (frm_valid_o && $stable(frm_addr_o) && $stable(frm_len_o)));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_valid_o && mem_req_o));

    p_wb_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_BIT]);

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_CTL && mem_ack_i && !mem_rdata_i[OWN_BIT] && !tx_req_set_i)
        |=> (!tx_req_o && state == ST_IDLE));

    p_stop_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_CTL && mem_ack_i && !mem_rdata_i[OWN_BIT]) |=> $stable(cur_ptr));

    p_base_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (base_load_i && tx_req_o && !(state == ST_WRITEBACK && mem_ack_i)) |=> $stable(cur_ptr));

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .tx_req_set_i(tx_req_set_i),
    .tx_req_o    (tx_req_o),
    .base_load_i (base_load_i),
    .cur_ptr     (cur_ptr),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_ack_i   (mem_ack_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .frm_valid_o (frm_valid_o),
    .frm_done_i  (frm_done_i),
    .frm_addr_o  (frm_addr_o),
    .frm_len_o   (frm_len_o)
);

// File: tb/tx_ring_engine_tb_top.sv
module tx_ring_engine_tb_top;
    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] LAST  = 32'h4000_0000;
    localparam logic [31:0] WHOLE = 32'h1000_0000;
    localparam logic [31:0] ERR   = 32'h0800_0000;
    localparam logic [31:0] RING_A = 32'h100;
    localparam logic [31:0] RING_B = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = '0;
    logic        base_load = 1'b0;
    logic        req_set = 1'b0;
    logic        tx_req, mem_req, mem_we, mem_ack = 1'b0, frm_valid, frm_done = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, frm_addr;
    logic [15:0] frm_len;

    logic [31:0] mem [0:255];
    logic [31:0] f_addr [0:31];
    logic [15:0] f_len  [0:31];
    int nf = 0, sink_delay = 2, sink_cnt = 0;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    tx_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base), .base_load_i(base_load),
        .tx_req_set_i(req_set), .tx_req_o(tx_req), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .frm_valid_o(frm_valid), .frm_addr_o(frm_addr),
        .frm_len_o(frm_len), .frm_done_i(frm_done)
    );

    // memory model: one-cycle acknowledge
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[9:2]];
            mem_ack = 1'b1;
        end
    end

    // frame sink with configurable latency
    always @(negedge clk) begin
        if (frm_done) frm_done = 1'b0;
        else if (frm_valid) begin
            if (sink_cnt >= sink_delay) begin
                if (nf < 32) begin f_addr[nf] = frm_addr; f_len[nf] = frm_len; end
                nf++;
                frm_done = 1'b1;
                sink_cnt = 0;
            end else sink_cnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int widx(input logic [31:0] base, input int k, input int w);
        return int'(base >> 2) + 4 * k + w;
    endfunction

    task automatic set_desc(input logic [31:0] base, input int k, input logic [31:0] ctl,
                            input logic [31:0] lenw, input logic [31:0] buf_a);
        mem[widx(base, k, 0)] = ctl;
        mem[widx(base, k, 1)] = lenw;
        mem[widx(base, k, 2)] = buf_a;
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk); ring_base = b; base_load = 1'b1;
        @(negedge clk); base_load = 1'b0;
    endtask

    task automatic start_req();
        @(negedge clk); req_set = 1'b1;
        @(negedge clk); req_set = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!tx_req) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 tx_req after reset", {31'b0, tx_req}, 32'd0);
        check("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
        check("R1 frm_valid after reset", {31'b0, frm_valid}, 32'd0);
        repeat (5) @(negedge clk);
        check("R1 still quiet without request", {30'b0, mem_req, frm_valid}, 32'd0);
    endtask

    task automatic t_single();
        set_desc(RING_A, 0, OWN | WHOLE | 32'h55, 32'h003C_ABCD, 32'h2000);
        set_desc(RING_A, 1, 32'h0, 32'h0, 32'h0);
        load_base(RING_A);
        start_req();
        wait_idle();
        check("R2 one frame sent", nf, 1);
        check("R3 frame address", f_addr[0], 32'h2000);
        check("R3 frame length upper half", {16'b0, f_len[0]}, 32'd60);
        check("R4 write-back clears owner", mem[widx(RING_A, 0, 0)], WHOLE | 32'h55);
        check("R6 tx_req cleared on stop", {31'b0, tx_req}, 32'd0);
        check("R6 unowned descriptor not written", mem[widx(RING_A, 1, 0)], 32'h0);
    endtask

    task automatic t_resume_wrap();
        set_desc(RING_A, 1, OWN | WHOLE, 32'h0064_0000, 32'h3000);
        set_desc(RING_A, 2, OWN | WHOLE | LAST, 32'hFFFF_1234, 32'h3100);
        set_desc(RING_A, 0, OWN | WHOLE, 32'h0008_0000, 32'h3200);
        start_req();
        wait_idle();
        check("R7 resumed at stopped descriptor", f_addr[1], 32'h3000);
        check("R3 length 100", {16'b0, f_len[1]}, 32'd100);
        check("R5 stride to next descriptor", f_addr[2], 32'h3100);
        check("R3 maximum length", {16'b0, f_len[2]}, 32'hFFFF);
        check("R5 wrap to ring base", f_addr[3], 32'h3200);
        check("R5 last bit preserved", mem[widx(RING_A, 2, 0)], WHOLE | LAST);
        check("R6 stop after wrap", nf, 4);
    endtask

    task automatic t_skip();
        set_desc(RING_A, 1, OWN | WHOLE, 32'h0014_0000, 32'h4002);
        set_desc(RING_A, 2, OWN, 32'h0014_0000, 32'h4100);
        set_desc(RING_A, 3, OWN | WHOLE | LAST, 32'h0000_FFFF, 32'h4200);
        start_req();
        wait_idle();
        check("R8 no frame for skipped", nf, 4);
        check("R8 misaligned flagged", mem[widx(RING_A, 1, 0)], WHOLE | ERR);
        check("R8 partial frame flagged", mem[widx(RING_A, 2, 0)], ERR);
        check("R8 zero length flagged", mem[widx(RING_A, 3, 0)], WHOLE | LAST | ERR);
    endtask

    task automatic t_base_busy();
        sink_delay = 20;
        set_desc(RING_A, 0, OWN | WHOLE, 32'h001E_0000, 32'h5000);
        set_desc(RING_A, 1, OWN | WHOLE | LAST, 32'h001F_0000, 32'h5004);
        set_desc(RING_B, 0, OWN | WHOLE | ERR, 32'h004D_0000, 32'h6000);
        set_desc(RING_B, 1, 32'h0, 32'h0, 32'h0);
        start_req();
        repeat (8) @(negedge clk);
        check("R9 engine busy at load", {31'b0, frm_valid}, 32'd1);
        load_base(RING_B);
        wait_idle();
        sink_delay = 2;
        check("R9 frames stay in old ring", nf, 6);
        check("R9 second frame old ring", f_addr[5], 32'h5004);
        set_desc(RING_A, 0, OWN | WHOLE | LAST, 32'h0028_0000, 32'h5008);
        start_req();
        wait_idle();
        check("R9 pointer kept after busy load", f_addr[6], 32'h5008);
        load_base(RING_B);
        start_req();
        wait_idle();
        check("R9 idle load takes effect", f_addr[7], 32'h6000);
        check("R4 error bit cleared on send", mem[widx(RING_B, 0, 0)], WHOLE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_resume_wrap();
        t_skip();
        t_base_busy();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule